// File: doc/BRIEF.md
# Link Activity Sync Detector

This block watches the data-enable strobe recovered from a video link and reports whether the link is alive. The strobe is asynchronous to the block clock, so it first passes through a two-flop synchroniser. Each rising transition of the synchronised strobe counts as one activity edge. The flag goes high once a parameterised number of these edges has been counted since the link was last declared lost.

A free-running prescaler divides the block clock into a slow tick. An idle timer counts ticks and restarts on every activity edge. When a full timeout of ticks passes with no edge, the flag drops and the edge count is cleared. A strobe held at a constant level therefore reads as a dead link, whether that level is high or low.

The flag is a plain, always-driven output with no power-down or tri-state path of its own. The flag can feed back into the output-disable input of the pixel formatter, so that the formatter's outputs turn off when no activity is seen. There is no valid/ready interface, because no data stream passes through the block: both the strobe input and the flag are plain control pins.

With the defaults at a 200 MHz clock, the flag rises after 16 edges. It falls between 19.99 ms and 20 ms after the last edge.

Top module: `link_activity_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `link_alive` is 0. The edge count starts at zero, and the idle timer starts in its expired state.
- R2: `de_in` is resynchronised through two flops before edge detection. Suppose `de_in` is first sampled high at clock edge k, and this rising transition completes the edge count. Then `link_alive` changes at clock edge k+2 and is still low after edge k+1.
- R3: `link_alive` rises once EDGE_COUNT rising edges of the synchronised strobe have been counted since reset or since the last timeout. The edge count saturates at EDGE_COUNT.
- R4: The prescaler runs freely from reset, independent of the strobe. It issues one tick on every PRESCALE-th clock, in clock cycles PRESCALE-1, 2*PRESCALE-1, and so on, counting from 0 at the first cycle after reset.
- R5: Every rising edge restarts the idle tick count at zero. If TIMEOUT_TICKS ticks occur with no rising edge, `link_alive` falls and the edge count returns to zero, both in the clock edge that ends the cycle of the final tick.
- R6: A gap between edges that is shorter than the timeout keeps the partial edge count. Edges before and after such a gap add up towards EDGE_COUNT.
- R7: A strobe held continuously high is treated as inactive. It causes the same timeout loss as a strobe held low.
- R8: After a loss, a single new edge does not raise `link_alive`. A full set of EDGE_COUNT fresh edges is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the timeout prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_in | input | 1 | Recovered data-enable strobe, asynchronous to `clk` |
| link_alive | output | 1 | High while the strobe is toggling; always driven |

## Verification
The bench aims at the edge of the two-stage synchroniser latency. It checks that the flag is still low one cycle before the expected rise and high in the expected cycle. A design with one stage too many or too few misses by one cycle. The bench also checks the case where the prescaler tick and the idle timer meet. A timer that does not restart on each edge, or that is compared one tick early or late, drops the flag in the wrong cycle, and the reference model, compared every clock, sees this.

Further checks cover a strobe stuck high, which a level-sensitive design would wrongly keep alive. They also cover a short gap inside a burst, where a design that clears the count too eagerly would never assert. Finally, a lone edge after a loss must not reassert the flag, which a design that does not clear its count on timeout would do.

// File: rtl/lad_pkg.sv
package lad_pkg;
  // Width of a counter that must hold values 0..max_val inclusive.
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/lad_sync.sv
module lad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lad_timebase.sv
module lad_timebase #(
  parameter int PRESCALE = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import lad_pkg::*;

  if (PRESCALE <= 1) begin : g_every
    assign tick = rst_n;
  end else begin : g_div
    localparam int PW = cnt_width(PRESCALE - 1);
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
  end
endmodule

// File: rtl/lad_idle_timer.sv
module lad_idle_timer #(
  parameter int TIMEOUT_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic act_edge,
  output logic expire
);
  import lad_pkg::*;

  localparam int TW = cnt_width(TIMEOUT_TICKS);
  localparam logic [TW-1:0] FULL = TW'(TIMEOUT_TICKS);
  localparam logic [TW-1:0] PRE  = TW'(TIMEOUT_TICKS - 1);

  logic [TW-1:0] idle_q;

  // Fires in the cycle of the tick that completes the idle window.
  assign expire = tick && !act_edge && (idle_q == PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idle_q <= FULL;
    else if (act_edge)               idle_q <= '0;
    else if (tick && idle_q != FULL) idle_q <= idle_q + 1'b1;
  end
endmodule

// File: rtl/lad_edge_acc.sv
module lad_edge_acc #(
  parameter int EDGE_COUNT = 16,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_edge,
  input  logic          expire,
  output logic          alive,
  output logic [EW-1:0] count
);
  localparam logic [EW-1:0] TOP  = EW'(EDGE_COUNT);
  localparam logic [EW-1:0] LAST = EW'(EDGE_COUNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      alive <= 1'b0;
    end else if (expire) begin
      count <= '0;
      alive <= 1'b0;
    end else if (act_edge) begin
      if (count != TOP) count <= count + 1'b1;
      if (count >= LAST) alive <= 1'b1;
    end
  end
endmodule

// File: rtl/link_activity_detector.sv
module link_activity_detector #(
  parameter int EDGE_COUNT    = 16,
  parameter int PRESCALE      = 2000,
  parameter int TIMEOUT_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de_in,
  output logic link_alive
);
  import lad_pkg::*;

  localparam int EW = cnt_width(EDGE_COUNT);

  logic de_sync;
  logic de_prev;
  logic de_rise;
  logic tick;
  logic timeout_hit;
  logic [EW-1:0] edge_cnt;

  lad_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(de_in), .q(de_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) de_prev <= 1'b0;
    else        de_prev <= de_sync;
  end

  assign de_rise = de_sync && !de_prev;

  lad_timebase #(.PRESCALE(PRESCALE)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lad_idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act_edge(de_rise),
    .expire(timeout_hit)
  );

  lad_edge_acc #(.EDGE_COUNT(EDGE_COUNT), .EW(EW)) u_acc (
    .clk(clk), .rst_n(rst_n), .act_edge(de_rise), .expire(timeout_hit),
    .alive(link_alive), .count(edge_cnt)
  );
endmodule

// File: rtl/link_activity_detector_chk.sv
module link_activity_detector_chk #(
  parameter int EDGE_COUNT = 16,
  parameter int EW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          de_rise,
  input logic          timeout_hit,
  input logic          link_alive,
  input logic [EW-1:0] edge_cnt
);
  // R3: the flag only rises in response to a counted edge
  assert_rise_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_alive) |-> $past(de_rise));

  // R3: the edge that completes the count raises the flag
  assert_full_count_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (de_rise && !timeout_hit && edge_cnt == EW'(EDGE_COUNT - 1)) |=> link_alive);

  // R5: the flag only falls on a timeout
  assert_fall_needs_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_alive) |-> $past(timeout_hit));

  // R5: a timeout clears both the flag and the count
  assert_timeout_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (!link_alive && edge_cnt == '0));

  // R8: the flag high implies a complete count
  assert_alive_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_alive |-> (edge_cnt == EW'(EDGE_COUNT)));

  // R3: the count never passes its saturation value
  always_comb begin
    if (rst_n) assert_count_bound_R3: assert (edge_cnt <= EW'(EDGE_COUNT));
  end
endmodule

bind link_activity_detector link_activity_detector_chk #(
  .EDGE_COUNT(EDGE_COUNT), .EW(EW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .de_rise(de_rise), .timeout_hit(timeout_hit),
  .link_alive(link_alive), .edge_cnt(edge_cnt)
);

// File: tb/tb_link_activity_detector.sv
`timescale 1ns/1ps
module tb_link_activity_detector;
  localparam int N = 4;
  localparam int P = 5;
  localparam int T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de_in = 1'b0;
  logic link_alive;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_activity_detector #(.EDGE_COUNT(N), .PRESCALE(P), .TIMEOUT_TICKS(T)) dut (
    .clk(clk), .rst_n(rst_n), .de_in(de_in), .link_alive(link_alive)
  );

  // Behavioural reference model
  int samples[$];
  int cyc;
  int idle_ticks;
  int edges;
  bit exp_alive;

  always @(posedge clk) begin
    if (!rst_n) begin
      samples = '{0, 0, 0};
      cyc = 0;
      idle_ticks = T;
      edges = 0;
      exp_alive = 1'b0;
    end else begin
      bit rise;
      bit tk;
      rise = (samples[1] == 1) && (samples[2] == 0);
      tk = ((cyc % P) == P - 1);
      cyc++;
      if (rise) begin
        idle_ticks = 0;
        if (edges < N) edges++;
        if (edges == N) exp_alive = 1'b1;
      end else if (tk && idle_ticks < T) begin
        idle_ticks++;
        if (idle_ticks == T) begin
          edges = 0;
          exp_alive = 1'b0;
        end
      end
      samples.push_front(int'(de_in));
      void'(samples.pop_back());
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (link_alive !== exp_alive) begin
        n_bad++;
        $display("FAIL %s model compare: actual=%b expected=%b at %0t",
                 cur_req, link_alive, exp_alive, $time);
      end
    end
  end

  task automatic check_val(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s direct check: actual=%b expected=%b at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    de_in = 1'b1;
    repeat (hi) @(negedge clk);
    de_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_val("R1", link_alive, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R1", link_alive, 1'b0);

    // R3: N edges raise the flag
    cur_req = "R3";
    repeat (N) pulse(2, 2);
    repeat (2) @(negedge clk);
    check_val("R3", link_alive, 1'b1);

    // R4 / R5: idle low, the flag must drop by the tick schedule
    cur_req = "R5";
    repeat (4) @(negedge clk);
    check_val("R5", link_alive, 1'b1);
    cur_req = "R4";
    repeat (30) @(negedge clk);
    check_val("R5", link_alive, 1'b0);

    // R6: a short gap keeps the partial count
    cur_req = "R6";
    repeat (N / 2) pulse(2, 2);
    repeat (4) @(negedge clk);
    check_val("R6", link_alive, 1'b0);
    repeat (N - N / 2) pulse(2, 2);
    repeat (2) @(negedge clk);
    check_val("R6", link_alive, 1'b1);

    // R7: strobe stuck high is a dead link
    cur_req = "R7";
    de_in = 1'b1;
    repeat (30) @(negedge clk);
    check_val("R7", link_alive, 1'b0);
    de_in = 1'b0;
    repeat (30) @(negedge clk);

    // R8: one edge after loss does not reassert
    cur_req = "R8";
    pulse(2, 6);
    check_val("R8", link_alive, 1'b0);

    // R2: exact two-stage latency on the completing edge
    cur_req = "R2";
    repeat (N - 2) pulse(2, 2);
    check_val("R2", link_alive, 1'b0);
    de_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_val("R2", link_alive, 1'b0);
    @(negedge clk);
    check_val("R2", link_alive, 1'b1);
    de_in = 1'b0;
    repeat (5) @(negedge clk);
    check_val("R3", link_alive, 1'b1);

    // R5: steady toggling keeps the flag up for a long time
    cur_req = "R5";
    repeat (20) pulse(3, 3);
    check_val("R5", link_alive, 1'b1);
    repeat (40) @(negedge clk);
    check_val("R5", link_alive, 1'b0);

    finish_run();
  end
endmodule